// File: doc/BRIEF.md
# Column-to-Row Coefficient Transposer

This block reorders the output of a column-wise one-dimensional wavelet stage so that a row-wise stage can consume it, inside a separable one-level two-dimensional decomposition of an image that is ROWS high and COLS wide. The column stage works on one pair of image rows (a stripe) at a time. Within a stripe it walks the columns left to right and, for each column, delivers the low-pass coefficient and then the high-pass coefficient. The row stage needs the whole low line of the stripe, left to right, followed by the whole high line.

Two line groups are used in ping-pong fashion. Each holds one stripe, that is one low line and one high line. While one group fills from the column side, the other drains to the row side. Row processing can therefore start as soon as a single stripe is complete, and internal storage stays at four lines. Each outgoing coefficient carries a two-bit subband tag naming the band its row-stage result falls into. A write strobe marks the beats whose results belong to the LL band, which is the only band kept in external memory for the next level. A start-of-frame input clears all progress. A one-cycle pulse follows the final beat of the frame.

Top module: `tpb_top`

## Requirements
- R1: After reset, out_valid, ll_we and frame_done are 0 and in_ready is 1.
- R2: Input beats within a stripe arrive as (column 0 low, column 0 high, column 1 low, ...). For every stripe, in stripe order, the output carries the COLS low coefficients in ascending column order and then the COLS high coefficients in ascending column order. No value is lost, duplicated or altered.
- R3: out_tag = {line, column parity}: 2'b00 LL (low line, even column), 2'b01 HL (low line, odd column), 2'b10 LH (high line, even column), 2'b11 HH (high line, odd column).
- R4: ll_we is 1 exactly in cycles where an output beat is accepted (out_valid and out_ready) and that beat has tag 2'b00.
- R5: When both line groups hold undrained stripes, in_ready is 0. With out_ready held low, exactly 4*COLS input beats are accepted before in_ready stays low.
- R6: When a stripe's last input beat is accepted and no earlier stripe is still waiting to be drained, out_valid is 1 in the very next cycle.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data and out_tag stay unchanged in the next cycle.
- R8: frame_done is a single-cycle pulse in the cycle after the last beat of the frame (the last HH beat) is accepted, and is 0 at all other times.
- R9: Once all ROWS*COLS input beats of a frame have been accepted, in_ready stays 0 until start-of-frame.
- R10: While sof is 1, in_ready is 0. In the cycle after sof, out_valid is 0 and in_ready is 1. Partially received data is discarded, and the next frame is reordered from its first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| sof | input | 1 | Start of frame; clears counters and line groups |
| in_valid | input | 1 | Column-stage coefficient valid |
| in_ready | output | 1 | Buffer can take a coefficient |
| in_data | input | W | Column-stage coefficient |
| out_valid | output | 1 | Row-ordered coefficient valid |
| out_ready | input | 1 | Row stage takes the coefficient |
| out_data | output | W | Row-ordered coefficient |
| out_tag | output | 2 | Subband tag of the coefficient |
| ll_we | output | 1 | Write strobe for the external LL store |
| frame_done | output | 1 | Pulse after the last beat of the frame |

## Verification
The hardest state to reach is both line groups full while the writer still has data. At equal rates the drain side empties a group exactly as the fill side completes the next one, so in_ready never drops. The stimulus gets there by holding out_ready low while keeping in_valid high, counting accepted beats until the stall, and then releasing the row side to check that the stalled data drains intact. A start-of-frame pulse issued in the middle of a stripe, followed by a fresh frame, covers the discard path. Random valid and ready densities across several frames cover the overlap of filling and draining.

// File: rtl/tpb_pkg.sv
package tpb_pkg;
   typedef enum logic [1:0] {
      SB_LL = 2'b00,
      SB_HL = 2'b01,
      SB_LH = 2'b10,
      SB_HH = 2'b11
   } subband_e;
endpackage

// File: rtl/tpb_wr_ctrl.sv
module tpb_wr_ctrl #(
   parameter int ROWS = 8,
   parameter int COLS = 16,
   localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int STRIPES = ROWS / 2,
   localparam int SW = $clog2(STRIPES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sof,
   input  logic          in_fire,
   output logic [CW-1:0] wr_col,
   output logic          wr_hi,
   output logic          wr_grp,
   output logic          stripe_done,
   output logic          frame_in_done
);
   logic [SW-1:0] stripes_q;

   assign stripe_done   = in_fire && wr_hi && (wr_col == CW'(COLS - 1));
   assign frame_in_done = (stripes_q == SW'(STRIPES));

   always_ff @(posedge clk) begin
      if (!rst_n || sof) begin
         wr_col    <= '0;
         wr_hi     <= 1'b0;
         wr_grp    <= 1'b0;
         stripes_q <= '0;
      end else if (in_fire) begin
         if (wr_hi) begin
            wr_hi <= 1'b0;
            if (wr_col == CW'(COLS - 1)) begin
               wr_col    <= '0;
               wr_grp    <= ~wr_grp;
               stripes_q <= stripes_q + SW'(1);
            end else begin
               wr_col <= wr_col + CW'(1);
            end
         end else begin
            wr_hi <= 1'b1;
         end
      end
   end

   // R2: a completed stripe restarts the column walk at column 0, low line
   a_r2_stripe_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (stripe_done && !sof) |=> (wr_col == '0 && !wr_hi));
endmodule

// File: rtl/tpb_store.sv
module tpb_store #(
   parameter int W = 12,
   parameter int COLS = 16,
   parameter int GROUPS = 2,
   localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
   input  logic          clk,
   input  logic          we,
   input  logic [GW-1:0] w_grp,
   input  logic          w_hi,
   input  logic [CW-1:0] w_col,
   input  logic [W-1:0]  w_data,
   input  logic [GW-1:0] r_grp,
   input  logic          r_hi,
   input  logic [CW-1:0] r_col,
   output logic [W-1:0]  r_data
);
   logic [W-1:0] grp_rd [GROUPS];

   for (genvar g = 0; g < GROUPS; g++) begin : g_group
      logic [W-1:0] lines [2][COLS];
      always_ff @(posedge clk) begin
         if (we && w_grp == GW'(g)) lines[w_hi][w_col] <= w_data;
      end
      assign grp_rd[g] = lines[r_hi][r_col];
   end

   assign r_data = grp_rd[r_grp];
endmodule

// File: rtl/tpb_rd_ctrl.sv
module tpb_rd_ctrl
   import tpb_pkg::*;
#(
   parameter int ROWS = 8,
   parameter int COLS = 16,
   localparam int CW = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int STRIPES = ROWS / 2,
   localparam int SW = $clog2(STRIPES + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sof,
   input  logic          grp_full,
   input  logic          out_ready,
   output logic [CW-1:0] rd_col,
   output logic          rd_hi,
   output logic          rd_grp,
   output logic          rd_stripe_done,
   output logic          out_valid,
   output subband_e      out_tag,
   output logic          ll_we,
   output logic          frame_done
);
   logic [SW-1:0] stripes_q;
   logic          out_fire;
   logic          last_beat;

   assign out_valid      = grp_full;
   assign out_fire       = grp_full && out_ready;
   assign out_tag        = subband_e'({rd_hi, rd_col[0]});
   assign ll_we          = out_fire && (out_tag == SB_LL);
   assign rd_stripe_done = out_fire && rd_hi && (rd_col == CW'(COLS - 1));
   assign last_beat      = rd_stripe_done && (stripes_q == SW'(STRIPES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || sof) begin
         rd_col     <= '0;
         rd_hi      <= 1'b0;
         rd_grp     <= 1'b0;
         stripes_q  <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= last_beat;
         if (out_fire) begin
            if (rd_col == CW'(COLS - 1)) begin
               rd_col <= '0;
               rd_hi  <= ~rd_hi;
               if (rd_hi) begin
                  rd_grp    <= ~rd_grp;
                  stripes_q <= last_beat ? '0 : stripes_q + SW'(1);
               end
            end else begin
               rd_col <= rd_col + CW'(1);
            end
         end
      end
   end

   // R8: the end-of-frame strobe never lasts two cycles
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);
   // R8: the strobe follows an accepted beat
   a_r8_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(out_fire));
endmodule

// File: rtl/tpb_top.sv
module tpb_top
   import tpb_pkg::*;
#(
   parameter int W = 12,
   parameter int ROWS = 8,
   parameter int COLS = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sof,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data,
   output logic [1:0]   out_tag,
   output logic         ll_we,
   output logic         frame_done
);
   localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;

   if (W < 1) begin : g_bad_w
      $error("tpb_top: W must be at least 1");
   end
   if (ROWS < 2 || (ROWS % 2) != 0) begin : g_bad_rows
      $error("tpb_top: ROWS must be even and at least 2");
   end
   if (COLS < 2 || (COLS % 2) != 0) begin : g_bad_cols
      $error("tpb_top: COLS must be even and at least 2");
   end

   logic [1:0]    full_q;
   logic [CW-1:0] wr_col, rd_col;
   logic          wr_hi, rd_hi, wr_grp, rd_grp;
   logic          wr_stripe_done, rd_stripe_done, frame_in_done;
   logic          in_fire;
   subband_e      tag;

   assign in_ready = !sof && !full_q[wr_grp] && !frame_in_done;
   assign in_fire  = in_valid && in_ready;
   assign out_tag  = tag;

   tpb_wr_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_wr (
      .clk(clk), .rst_n(rst_n), .sof(sof), .in_fire(in_fire),
      .wr_col(wr_col), .wr_hi(wr_hi), .wr_grp(wr_grp),
      .stripe_done(wr_stripe_done), .frame_in_done(frame_in_done)
   );

   tpb_store #(.W(W), .COLS(COLS), .GROUPS(2)) u_store (
      .clk(clk), .we(in_fire), .w_grp(wr_grp), .w_hi(wr_hi), .w_col(wr_col),
      .w_data(in_data), .r_grp(rd_grp), .r_hi(rd_hi), .r_col(rd_col),
      .r_data(out_data)
   );

   tpb_rd_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_rd (
      .clk(clk), .rst_n(rst_n), .sof(sof), .grp_full(full_q[rd_grp]),
      .out_ready(out_ready), .rd_col(rd_col), .rd_hi(rd_hi), .rd_grp(rd_grp),
      .rd_stripe_done(rd_stripe_done), .out_valid(out_valid), .out_tag(tag),
      .ll_we(ll_we), .frame_done(frame_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || sof) begin
         full_q <= 2'b00;
      end else begin
         for (int g = 0; g < 2; g++) begin
            if (wr_stripe_done && wr_grp == g[0]) full_q[g] <= 1'b1;
            else if (rd_stripe_done && rd_grp == g[0]) full_q[g] <= 1'b0;
         end
      end
   end

   // R5: no acceptance while both groups wait for the row stage
   a_r5_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q == 2'b11) |-> !in_ready);
   // R7: a stalled beat is held unchanged
   a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !sof) |=> (out_valid && $stable(out_data) && $stable(out_tag)));
   // R10: start of frame flushes both groups
   a_r10_sof_flush: assert property (@(posedge clk) disable iff (!rst_n)
      sof |=> !out_valid);
   // R3: an LL beat is always followed by its HL partner
   a_r3_ll_then_hl: assert property (@(posedge clk) disable iff (!rst_n)
      (ll_we && !sof) |=> (!out_valid || out_tag == 2'b01));
endmodule

// File: tb/tpb_top_test.sv
module tpb_top_test;
   localparam int W = 12;
   localparam int ROWS = 8;
   localparam int COLS = 16;
   localparam int STRIPES = ROWS / 2;
   localparam int TOTAL = ROWS * COLS;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sof = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [W-1:0] in_data = '0;
   logic         out_valid;
   logic         out_ready = 1'b0;
   logic [W-1:0] out_data;
   logic [1:0]   out_tag;
   logic         ll_we;
   logic         frame_done;

   int errors = 0;
   int checks = 0;

   logic [W-1:0] vals [STRIPES][2][COLS];
   int in_cnt, out_cnt, wstripes, rstripes;
   bit pend_done, held, expect_valid;
   logic [W-1:0] held_data;
   logic [1:0]   held_tag;

   always #5 clk = ~clk;

   tpb_top #(.W(W), .ROWS(ROWS), .COLS(COLS)) uut (
      .clk(clk), .rst_n(rst_n), .sof(sof), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_tag(out_tag), .ll_we(ll_we), .frame_done(frame_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_tag(input int hi, input int col);
      return {hi[0], col[0]};
   endfunction

   task automatic model_clear();
      in_cnt = 0; out_cnt = 0; wstripes = 0; rstripes = 0;
      pend_done = 0; held = 0; expect_valid = 0;
   endtask

   task automatic step(input bit iv, input bit orq);
      bit ofire, ifire;
      int op, oh, ox, ip, ih, ix;
      @(negedge clk);
      in_valid = iv;
      in_data = W'($urandom);
      out_ready = orq;
      #1;
      chk(frame_done == pend_done, "R8", "frame_done", int'(frame_done), int'(pend_done));
      pend_done = 0;
      if (held) begin
         chk(out_valid == 1'b1, "R7", "valid held", int'(out_valid), 1);
         chk(out_data == held_data, "R7", "data held", int'(out_data), int'(held_data));
         chk(out_tag == held_tag, "R7", "tag held", int'(out_tag), int'(held_tag));
      end
      held = out_valid && !out_ready;
      held_data = out_data;
      held_tag = out_tag;
      if (expect_valid) chk(out_valid == 1'b1, "R6", "valid after stripe", int'(out_valid), 1);
      expect_valid = 0;
      if (in_cnt == TOTAL) chk(in_ready == 1'b0, "R9", "ready after frame", int'(in_ready), 0);
      ofire = out_valid && out_ready;
      op = out_cnt / (2 * COLS);
      oh = (out_cnt / COLS) % 2;
      ox = out_cnt % COLS;
      chk(ll_we == (ofire && oh == 0 && ox % 2 == 0), "R4", "ll_we", int'(ll_we),
          int'(ofire && oh == 0 && ox % 2 == 0));
      if (ofire) begin
         if (out_cnt < in_cnt && op < STRIPES) begin
            chk(out_data == vals[op][oh][ox], "R2", "data order", int'(out_data),
                int'(vals[op][oh][ox]));
            chk(out_tag == exp_tag(oh, ox), "R3", "tag", int'(out_tag), int'(exp_tag(oh, ox)));
         end else begin
            chk(1'b0, "R2", "beat without input", out_cnt, in_cnt);
         end
         out_cnt++;
         if (out_cnt % (2 * COLS) == 0) rstripes++;
         if (out_cnt == TOTAL) pend_done = 1;
      end
      ifire = in_valid && in_ready;
      if (ifire) begin
         ip = in_cnt / (2 * COLS);
         ix = (in_cnt / 2) % COLS;
         ih = in_cnt % 2;
         vals[ip][ih][ix] = in_data;
         in_cnt++;
         if (in_cnt % (2 * COLS) == 0) begin
            if (wstripes == rstripes) expect_valid = 1;
            wstripes++;
         end
      end
   endtask

   task automatic do_sof();
      @(negedge clk);
      sof = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
      #1;
      chk(in_ready == 1'b0, "R10", "ready during sof", int'(in_ready), 0);
      @(negedge clk);
      sof = 1'b0;
      #1;
      chk(out_valid == 1'b0, "R10", "valid after sof", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R10", "ready after sof", int'(in_ready), 1);
      model_clear();
   endtask

   task automatic run_frame(input int in_pct, input int out_pct);
      int guard = 0;
      while (out_cnt < TOTAL && guard < 20000) begin
         step(in_cnt < TOTAL && ($urandom % 100) < in_pct, ($urandom % 100) < out_pct);
         guard++;
      end
      step(1'b0, 1'b1);
      chk(out_cnt == TOTAL, "R2", "beats per frame", out_cnt, TOTAL);
   endtask

   initial begin
      #2000000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240607));
      model_clear();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R1", "in_ready", int'(in_ready), 1);
      chk(ll_we == 1'b0, "R1", "ll_we", int'(ll_we), 0);
      chk(frame_done == 1'b0, "R1", "frame_done", int'(frame_done), 0);

      run_frame(100, 100);

      do_sof();
      run_frame(60, 70);

      // R5: stall the row side and fill both groups
      do_sof();
      for (int i = 0; i < 4 * COLS + 6; i++) step(1'b1, 1'b0);
      chk(in_cnt == 4 * COLS, "R5", "accepted before stall", in_cnt, 4 * COLS);
      #1;
      chk(in_ready == 1'b0, "R5", "ready with both full", int'(in_ready), 0);
      run_frame(100, 50);

      // R10: abandon a frame mid-stripe, then a clean frame
      do_sof();
      for (int i = 0; i < COLS + 3; i++) step(1'b1, 1'b1);
      do_sof();
      run_frame(80, 90);

      for (int f = 0; f < 3; f++) begin
         do_sof();
         run_frame(30 + 30 * f, 90 - 25 * f);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule